// File: doc/BRIEF.md
# CPU Hotplug Control Register Block

This block is the hardware side of a CPU hot-add and hot-remove scheme. Guest firmware sees a 12-byte window on a byte-addressed register bus. A selector register picks one CPU, and the other registers then act on that CPU only. A command register changes what the shared data register returns or accepts. Platform logic pulses per-CPU insert and remove-request inputs. The block records these as pending events and raises an SCI request line until firmware has acknowledged every one of them.

Firmware issues the scan command to find a CPU with a pending event. It reads that CPU's status and architecture ID, then clears the events through the control byte. It can also start an eject, or hand the eject over to firmware. The block reports an eject as a one-cycle strobe with the CPU index. Firmware writes the OST event and OST status codes through the data register, and the status write produces a report strobe that carries both values.

Top module: `cpu_hotplug_regs`

## Requirements
- R1: The accepted accesses are these, with size 1 meaning dword and 0 meaning byte: selector write at offset 0 (dword), data-high read at offset 0 (dword), status read and control write at offset 4 (byte), command write at offset 5 (byte), and data at offset 8 (dword) in both directions. Any other offset or size is ignored on writes and reads as 0. This includes every read at offset 5.
- R2: While the stored selector is not below NUM_CPUS, every read returns 0 and every write except a selector write is ignored.
- R3: The synchronous reset clears all per-CPU flags, the command (to 0), the OST registers and both strobes, and leaves the selector unchanged. At power-up the selector holds 0.
- R4: The status byte is bit0 enabled, bit1 insert pending, bit2 remove pending, bit4 firmware-eject requested, with bits 3 and 5 to 7 reading 0.
- R5: A one-cycle insert input pulse for CPU i sets that CPU's enabled and insert-pending flags. A remove-request pulse sets remove-pending. The sci output is high exactly while any CPU has insert or remove pending.
- R6: Writing control bit1 = 1 clears insert-pending of the selected CPU, and bit2 = 1 clears its remove-pending. Zero bits change nothing.
- R7: Control bit4 = 1 sets the firmware-eject request. Control bit3 = 1 clears enabled and the firmware-eject request, and in the following cycle raises eject_strobe for one cycle with eject_idx equal to the selector. Bit3 wins over bit4 in the same write.
- R8: Writing command 0 moves the selector to the first CPU with a pending insert or remove event, searching from selector+1 upward with wrap-around, so the current CPU is checked last. If no CPU has a pending event, the selector and all flags are unchanged.
- R9: With command 0, the data register (offset 8) reads the selector and data-high (offset 0) reads 0.
- R10: With command 3, the data register reads bits 31:0 of the selected CPU's 64-bit architecture ID and data-high reads bits 63:32.
- R11: With any command other than 0 or 3, both the data register and data-high read 0.
- R12: With command 1, a data write loads ost_event. With command 2, a data write loads ost_status and, in the following cycle, raises ost_strobe for one cycle while ost_event and ost_status show the current values. Data writes under any other command change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (selector excluded) |
| acc_valid | input | 1 | Bus access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 1 | 0 = byte, 1 = dword |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational in the access cycle |
| insert_req | input | NUM_CPUS | Per-CPU insert pulse |
| remove_req | input | NUM_CPUS | Per-CPU remove-request pulse |
| cpu_arch_ids | input | 64*NUM_CPUS | Constant 64-bit ID per CPU, CPU i at bits 64i+63:64i |
| eject_strobe | output | 1 | One-cycle eject pulse |
| eject_idx | output | $clog2(NUM_CPUS) | CPU index for eject_strobe |
| ost_strobe | output | 1 | One-cycle OST report pulse |
| ost_event | output | 32 | OST event register |
| ost_status | output | 32 | OST status register |
| sci | output | 1 | SCI request, high while events are pending |

## Verification
The scan is driven with directed patterns that tell its orderings apart. Two pending CPUs on both sides of the selector show that the search moves upward from selector+1. Wrap-around is shown by a pending CPU only below the selector, and "current CPU last" by a pending event only on the selected CPU. An empty pending set shows that the selector does not move. Random sequences mix selector values inside and just beyond the range with all command codes, arbitrary control bytes, platform pulses and reads at legal and illegal offsets and sizes. Each read is compared with a bench model, which separates blanking by the selector from decoding by size and offset and by command. A reset in mid-sequence with a nonzero selector shows that the selector is kept while all other state clears.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam logic [3:0] OFS_SEL  = 4'h0;
    localparam logic [3:0] OFS_CTL  = 4'h4;
    localparam logic [3:0] OFS_CMD  = 4'h5;
    localparam logic [3:0] OFS_DATA = 4'h8;

    localparam logic [7:0] CMD_SCAN    = 8'd0;
    localparam logic [7:0] CMD_OST_EV  = 8'd1;
    localparam logic [7:0] CMD_OST_ST  = 8'd2;
    localparam logic [7:0] CMD_ARCH_ID = 8'd3;

    typedef enum logic {SZ_BYTE = 1'b0, SZ_DWORD = 1'b1} acc_size_e;

    typedef struct packed {
        logic fw_eject;
        logic remove;
        logic insert;
        logic enabled;
    } cpu_state_t;

    typedef struct packed {
        logic clr_ins;
        logic clr_rem;
        logic eject;
        logic to_fw;
    } ctl_cmd_t;

    function automatic ctl_cmd_t decode_ctl(input logic [7:0] b);
        ctl_cmd_t c;
        c.clr_ins = b[1];
        c.clr_rem = b[2];
        c.eject   = b[3];
        c.to_fw   = b[4];
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input cpu_state_t s);
        return {3'b000, s.fw_eject, 1'b0, s.remove, s.insert, s.enabled};
    endfunction
endpackage

// File: rtl/hp_cpu_slot.sv
module hp_cpu_slot
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ins_set,
    input  logic       rem_set,
    input  logic       ctl_we,
    input  ctl_cmd_t   ctl,
    output cpu_state_t state
);
    cpu_state_t nxt;

    always_comb begin
        nxt = state;
        if (ctl_we) begin
            if (ctl.clr_ins) nxt.insert = 1'b0;
            if (ctl.clr_rem) nxt.remove = 1'b0;
            if (ctl.to_fw)   nxt.fw_eject = 1'b1;
            if (ctl.eject) begin
                nxt.enabled  = 1'b0;
                nxt.fw_eject = 1'b0;
            end
        end
        if (ins_set) begin
            nxt.enabled = 1'b1;
            nxt.insert  = 1'b1;
        end
        if (rem_set) nxt.remove = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

    p_insert_sets_r5: assert property (@(posedge clk) disable iff (rst)
        ins_set |=> (state.enabled && state.insert));
    p_remove_sets_r5: assert property (@(posedge clk) disable iff (rst)
        rem_set |=> state.remove);
    p_eject_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl.eject && !ins_set) |=> (!state.enabled && !state.fw_eject));
    p_fw_handover_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl.to_fw && !ctl.eject) |=> state.fw_eject);
endmodule

// File: rtl/hp_event_scan.sv
module hp_event_scan #(
    parameter int NUM_CPUS = 8,
    localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic [NUM_CPUS-1:0] pending,
    input  logic [IDX_W-1:0]    start,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = start;
        for (int k = 1; k <= NUM_CPUS; k++) begin
            int j;
            j = int'(start) + k;
            if (j >= NUM_CPUS) j = j - NUM_CPUS;
            if (!hit && pending[j]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/cpu_hotplug_regs.sv
module cpu_hotplug_regs
    import hp_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acc_valid,
    input  logic                     acc_write,
    input  logic [3:0]               acc_addr,
    input  logic                     acc_size,
    input  logic [31:0]              acc_wdata,
    output logic [31:0]              rd_data,
    input  logic [NUM_CPUS-1:0]      insert_req,
    input  logic [NUM_CPUS-1:0]      remove_req,
    input  logic [64*NUM_CPUS-1:0]   cpu_arch_ids,
    output logic                     eject_strobe,
    output logic [IDX_W-1:0]         eject_idx,
    output logic                     ost_strobe,
    output logic [31:0]              ost_event,
    output logic [31:0]              ost_status,
    output logic                     sci
);
    // Selector: not touched by rst, defined at power-up.
    logic [31:0]   sel_q = '0;
    logic [7:0]    cmd_q;
    logic          sel_ok;
    logic [IDX_W-1:0] sel_idx;

    cpu_state_t    states [NUM_CPUS];
    logic [NUM_CPUS-1:0] pend_vec;
    cpu_state_t    cur;
    logic [63:0]   cur_id;

    logic is_byte, is_dword, wr, rd;
    logic sel_we, ctl_we, cmd_we, dat_we;
    ctl_cmd_t ctl;
    logic scan_hit;
    logic [IDX_W-1:0] scan_idx;

    assign sel_ok   = (sel_q < 32'(NUM_CPUS));
    assign sel_idx  = sel_q[IDX_W-1:0];
    assign is_byte  = (acc_size == SZ_BYTE);
    assign is_dword = (acc_size == SZ_DWORD);
    assign wr       = acc_valid && acc_write;
    assign rd       = acc_valid && !acc_write;

    assign sel_we = wr && (acc_addr == OFS_SEL)  && is_dword;
    assign ctl_we = wr && (acc_addr == OFS_CTL)  && is_byte  && sel_ok;
    assign cmd_we = wr && (acc_addr == OFS_CMD)  && is_byte  && sel_ok;
    assign dat_we = wr && (acc_addr == OFS_DATA) && is_dword && sel_ok;
    assign ctl    = decode_ctl(acc_wdata[7:0]);

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slot
        hp_cpu_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .ins_set (insert_req[i]),
            .rem_set (remove_req[i]),
            .ctl_we  (ctl_we && (sel_idx == IDX_W'(i))),
            .ctl     (ctl),
            .state   (states[i])
        );
        assign pend_vec[i] = states[i].insert || states[i].remove;
    end

    hp_event_scan #(.NUM_CPUS(NUM_CPUS)) u_scan (
        .pending (pend_vec),
        .start   (sel_idx),
        .hit     (scan_hit),
        .hit_idx (scan_idx)
    );

    assign sci    = |pend_vec;
    assign cur    = states[sel_idx];
    assign cur_id = cpu_arch_ids[64*sel_idx +: 64];

    always_ff @(posedge clk) begin
        if (sel_we)
            sel_q <= acc_wdata;
        else if (cmd_we && acc_wdata[7:0] == CMD_SCAN && scan_hit)
            sel_q <= 32'(scan_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q        <= CMD_SCAN;
            ost_event    <= '0;
            ost_status   <= '0;
            ost_strobe   <= 1'b0;
            eject_strobe <= 1'b0;
            eject_idx    <= '0;
        end else begin
            ost_strobe   <= 1'b0;
            eject_strobe <= 1'b0;
            if (cmd_we) cmd_q <= acc_wdata[7:0];
            if (dat_we && cmd_q == CMD_OST_EV) ost_event <= acc_wdata;
            if (dat_we && cmd_q == CMD_OST_ST) begin
                ost_status <= acc_wdata;
                ost_strobe <= 1'b1;
            end
            if (ctl_we && ctl.eject) begin
                eject_strobe <= 1'b1;
                eject_idx    <= sel_idx;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd && sel_ok) begin
            case (acc_addr)
                OFS_SEL:
                    if (is_dword && cmd_q == CMD_ARCH_ID) rd_data = cur_id[63:32];
                OFS_CTL:
                    if (is_byte) rd_data = {24'd0, status_byte(cur)};
                OFS_DATA:
                    if (is_dword) begin
                        if (cmd_q == CMD_SCAN)         rd_data = sel_q;
                        else if (cmd_q == CMD_ARCH_ID) rd_data = cur_id[31:0];
                    end
                default: rd_data = '0;
            endcase
        end
    end

    p_blank_reads_r2: assert property (@(posedge clk) disable iff (rst)
        (rd && !sel_ok) |-> (rd_data == 32'd0));
    p_blocked_ctl_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && acc_addr == OFS_CTL && !sel_ok && !(|insert_req) && !(|remove_req))
        |=> $stable(pend_vec));
    p_scan_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && acc_wdata[7:0] == CMD_SCAN && (|pend_vec))
        |=> (sel_ok && pend_vec[sel_idx]));
    p_ost_report_r12: assert property (@(posedge clk) disable iff (rst)
        (dat_we && cmd_q == CMD_OST_ST) |=> (ost_strobe && ost_status == $past(acc_wdata)));
    p_eject_index_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl.eject) |=> (eject_strobe && eject_idx == $past(sel_idx)));
endmodule

// File: tb/sim_cpu_hotplug_regs.sv
`timescale 1ns/1ps
module sim_cpu_hotplug_regs;
    localparam int N = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_size = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [N-1:0] insert_req = '0, remove_req = '0;
    logic [64*N-1:0] cpu_arch_ids;
    logic eject_strobe, ost_strobe, sci;
    logic [IW-1:0] eject_idx;
    logic [31:0] ost_event, ost_status;

    always #2 clk = ~clk;

    cpu_hotplug_regs #(.NUM_CPUS(N)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .insert_req(insert_req), .remove_req(remove_req),
        .cpu_arch_ids(cpu_arch_ids), .eject_strobe(eject_strobe),
        .eject_idx(eject_idx), .ost_strobe(ost_strobe), .ost_event(ost_event),
        .ost_status(ost_status), .sci(sci)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    bit m_en [N], m_ins [N], m_rem [N], m_fw [N];
    logic [31:0] m_sel = 0, m_ev = 0, m_st = 0;
    logic [7:0]  m_cmd = 0;

    function automatic logic [63:0] id_of(input int i);
        return {32'hC0DE_0000 | 32'(i), 32'h0000_1000 + 32'(i * 17)};
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_ids
        assign cpu_arch_ids[64*g +: 64] = id_of(g);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_sci();
        for (int i = 0; i < N; i++) if (m_ins[i] || m_rem[i]) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic dw);
        logic [63:0] id;
        if (m_sel >= N) return 0;
        id = id_of(int'(m_sel));
        case (a)
            4'h0: return (dw && m_cmd == 3) ? id[63:32] : 32'd0;
            4'h4: return dw ? 32'd0 : {24'd0, 3'b000, m_fw[m_sel], 1'b0, m_rem[m_sel], m_ins[m_sel], m_en[m_sel]};
            4'h8: begin
                if (!dw) return 0;
                if (m_cmd == 0) return m_sel;
                if (m_cmd == 3) return id[31:0];
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a, input logic dw);
        if (m_sel >= N) return "R2";
        if (!((a == 0 && dw) || (a == 4 && !dw) || (a == 8 && dw))) return "R1";
        if (a == 4) return "R4";
        if (m_cmd == 0) return "R9";
        if (m_cmd == 3) return "R10";
        return "R11";
    endfunction

    task automatic model_scan();
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(m_sel) + k) % N;
            if (m_ins[j] || m_rem[j]) begin
                m_sel = 32'(j);
                return;
            end
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic dw, input logic [31:0] d, input string req);
        bit x_ej = 0, x_ost = 0;
        logic [31:0] x_idx = 0;
        if (a == 0 && dw) m_sel = d;
        else if (m_sel < N) begin
            if (a == 4 && !dw) begin
                if (d[1]) m_ins[m_sel] = 0;
                if (d[2]) m_rem[m_sel] = 0;
                if (d[4]) m_fw[m_sel] = 1;
                if (d[3]) begin m_en[m_sel] = 0; m_fw[m_sel] = 0; x_ej = 1; x_idx = m_sel; end
            end else if (a == 5 && !dw) begin
                m_cmd = d[7:0];
                if (d[7:0] == 0) model_scan();
            end else if (a == 8 && dw) begin
                if (m_cmd == 1) m_ev = d;
                else if (m_cmd == 2) begin m_st = d; x_ost = 1; end
            end
        end
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = dw; acc_wdata = d;
        @(posedge clk); #1;
        acc_valid = 0; acc_write = 0;
        chk(eject_strobe == x_ej, {req, "/R7 eject strobe"}, 32'(eject_strobe), 32'(x_ej));
        if (x_ej) chk(32'(eject_idx) == x_idx, "R7 eject index", 32'(eject_idx), x_idx);
        chk(ost_strobe == x_ost, {req, "/R12 ost strobe"}, 32'(ost_strobe), 32'(x_ost));
        chk(ost_event == m_ev && ost_status == m_st, {req, "/R12 ost values"}, ost_status, m_st);
        chk(sci == exp_sci(), {req, "/R5 sci"}, 32'(sci), 32'(exp_sci()));
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic dw, input string req);
        logic [31:0] e;
        e = exp_read(a, dw);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = dw;
        #1;
        chk(rd_data == e, req, rd_data, e);
        acc_valid = 0;
    endtask

    task automatic plat(input int i, input bit ins);
        if (ins) begin m_en[i] = 1; m_ins[i] = 1; end
        else m_rem[i] = 1;
        @(negedge clk);
        if (ins) insert_req[i] = 1'b1; else remove_req[i] = 1'b1;
        @(posedge clk); #1;
        insert_req = '0; remove_req = '0;
        chk(sci == 1'b1, "R5 sci after event", 32'(sci), 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(posedge clk);
        #1; rst = 0;
        for (int i = 0; i < N; i++) begin m_en[i] = 0; m_ins[i] = 0; m_rem[i] = 0; m_fw[i] = 0; end
        m_cmd = 0; m_ev = 0; m_st = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R3 reset state
        chk(sci == 0 && eject_strobe == 0 && ost_strobe == 0, "R3 outputs after reset", 32'(sci), 0);
        chk(ost_event == 0 && ost_status == 0, "R3 ost cleared", ost_event, 0);
        bus_rd(4'h8, 1, "R3 selector at power-up (R9)");
        bus_rd(4'h4, 0, "R3 status cleared (R4)");

        // R8 scan ordering
        plat(2, 1); plat(6, 1);
        bus_wr(4'h0, 1, 32'd4, "R8");
        bus_wr(4'h5, 0, 32'd0, "R8");
        bus_rd(4'h8, 1, "R8 upward from selector+1");
        bus_rd(4'h4, 0, "R4 insert status");
        bus_wr(4'h4, 0, 32'h02, "R6");
        bus_wr(4'h5, 0, 32'd0, "R8");
        bus_rd(4'h8, 1, "R8 wrap-around");
        bus_wr(4'h4, 0, 32'h02, "R6");
        plat(2, 0);
        bus_wr(4'h5, 0, 32'd0, "R8");
        bus_rd(4'h8, 1, "R8 current CPU checked last");
        bus_wr(4'h4, 0, 32'h04, "R6");
        bus_wr(4'h5, 0, 32'd0, "R8");
        bus_rd(4'h8, 1, "R8 no pending keeps selector");
        bus_rd(4'h4, 0, "R6 flags cleared");

        // R7 eject paths
        bus_wr(4'h4, 0, 32'h10, "R7");
        bus_rd(4'h4, 0, "R7 firmware request set");
        bus_wr(4'h4, 0, 32'h18, "R7");
        bus_rd(4'h4, 0, "R7 eject clears enabled and request");

        // R2 invalid selector
        bus_wr(4'h0, 1, 32'(N), "R2");
        bus_rd(4'h8, 1, "R2 blank data");
        bus_wr(4'h4, 0, 32'h18, "R2 control ignored");
        bus_wr(4'h5, 0, 32'd3, "R2 command ignored");
        bus_wr(4'h0, 1, 32'd5, "R2");
        bus_rd(4'h0, 1, "R2 command unchanged (R9)");

        // R10/R12 commands
        bus_wr(4'h5, 0, 32'd3, "R10");
        bus_rd(4'h8, 1, "R10 id low");
        bus_rd(4'h0, 1, "R10 id high");
        bus_rd(4'h0, 0, "R1 byte read of dword");
        bus_rd(4'h5, 0, "R1 offset 5 read");
        bus_wr(4'h5, 0, 32'd1, "R12");
        bus_wr(4'h8, 1, 32'hA5A5_0001, "R12 event load");
        bus_wr(4'h5, 0, 32'd2, "R12");
        bus_wr(4'h8, 1, 32'h0000_0080, "R12 status report");
        bus_rd(4'h8, 1, "R11 command 2 reads zero");

        // R3 reset keeps selector
        bus_wr(4'h5, 0, 32'd3, "R3");
        plat(5, 1);
        do_reset();
        bus_rd(4'h8, 1, "R3 selector kept across reset");
        bus_rd(4'h4, 0, "R3 flags cleared by reset");
        chk(sci == 0, "R3 sci after reset", 32'(sci), 0);

        // random mix
        for (int it = 0; it < 2000; it++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0: bus_wr(4'h0, 1, $urandom % (N + 3), "R2 selector");
                1: bus_wr(4'h4, 0, $urandom % 256, "R6 control");
                2: bus_wr(4'h5, 0, $urandom % 5, "R8 command");
                3: bus_wr(4'h8, 1, $urandom, "R12 data");
                4: plat(int'($urandom % N), 1);
                5: plat(int'($urandom % N), 0);
                6: begin
                    logic [3:0] a;
                    a = 4'($urandom % 16);
                    bus_wr(a, 1'($urandom % 2), $urandom, "R1 any write");
                end
                default: begin
                    logic [3:0] a;
                    logic dw;
                    case ($urandom % 6)
                        0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h5;
                        3: a = 4'h8; 4: a = 4'h2; default: a = 4'hC;
                    endcase
                    dw = 1'($urandom % 2);
                    bus_rd(a, dw, req_of(a, dw));
                end
            endcase
        end
        finish_run();
    end
endmodule